// File: doc/BRIEF.md
# SMBus Indexed Block-Access Register Target

This block is the target side of a two-wire SMBus/I2C link that gives a host access to a small bank of byte-wide configuration registers. The host reaches the bank with indexed block transfers. Every transfer carries an explicit byte count. In a write, the host sends a register index, then a count, then that many data bytes. In a read, the host first sets the index with a write-direction header and then issues a repeated START with the read direction. The target answers with the value of a dedicated count register, followed by consecutive register bytes.

SCL and SDA arrive as open-drain line levels. Both are passed through two-flop synchronisers and sampled on the system clock. START is recognised as an SDA fall while SCL is high, and STOP as an SDA rise while SCL is high. The target pulls SDA low through a single output-enable pin. Two three-level strap inputs pick one of nine slave addresses. The full register image is presented on a flat output port, so neighbouring logic can use individual bits as output-enable controls. The register index advances after every data byte and wraps at the bank size.

The controller is one finite-state machine with these states:
- IDLE: waiting for a START.
- ADDR: receiving the address byte.
- ADDR_ACK: acknowledging the address.
- INDEX and INDEX_ACK: receiving and acknowledging the index.
- COUNT and COUNT_ACK: receiving and acknowledging the write count.
- WDATA and WDATA_ACK: receiving and acknowledging data.
- TX: shifting a byte out.
- TX_ACK: sampling the host's acknowledge.
- WAIT: ignoring the bus until the next START or STOP.

Transitions:
- A STOP from any state leads to IDLE. A START from any state leads to ADDR.
- ADDR goes to ADDR_ACK on an address match and to WAIT otherwise.
- ADDR_ACK goes to INDEX for a write and to TX for a read.
- INDEX goes to INDEX_ACK, then COUNT, then COUNT_ACK, then WDATA.
- WDATA goes to WDATA_ACK while the count is not used up, and to WAIT once it is. WDATA_ACK returns to WDATA.
- TX goes to TX_ACK. TX_ACK returns to TX if the host acknowledged, and goes to WAIT on a NACK.

Top module: `smb_blk_target`

## Requirements
- R1: The slave address is BASE_ADDR + 3*L1 + L0. Each strap level L comes from its 2-bit strap code: 2'b00 gives 0, 2'b01 gives 1, and 2'b10 or 2'b11 gives 2. On a matching address byte the target drives SDA low during the ninth clock.
- R2: On a non-matching address, the target never drives SDA until the next START. It changes no register.
- R3: In a write, the byte after the address is the index N (its low bits). The next byte is the count X. Data bytes are then stored at N, N+1, and so on. Each stored byte is acknowledged.
- R4: The register index wraps from NREG-1 to 0, for writes and for reads.
- R5: Data bytes beyond the write count X are NACKed and not stored. With X = 0, the first data byte is already NACKed.
- R6: In a read, the first byte sent is the current value of the count register at index CNT_IDX. The bytes that follow are the registers from the index last set, in ascending order.
- R7: Once as many register bytes have been sent as the count value captured at the read address, every further byte the host requests reads 8'hFF.
- R8: The target changes SDA only while SCL is low. After a host NACK it releases SDA and keeps it released.
- R9: After reset, every register reads RST_VAL. The exceptions are the count register, which reads DEF_CNT, and the read-only register at RO_IDX, which reads RO_VAL.
- R10: A data byte written to RO_IDX is acknowledged and advances the index, but leaves the register at RO_VAL.
- R11: A STOP, or a START arriving mid-transfer or mid-byte, abandons the transfer without storing the partial data. An address byte that follows a START is handled afresh.
- R12: The count register is writable like any other register. The value written sets the count byte returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel0_i | input | 2 | Strap code for address level L0 |
| addr_sel1_i | input | 2 | Strap code for address level L1 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| regs_o | output | NREG*8 | Register image, register i at bits [8i+7:8i] |

## Verification
The bench uses the default parameters:
- a 16-entry bank
- base address 7'h68
- count register at index 8, resetting to 8
- a read-only register at index 15 holding 8'h5A

A three-byte write starting at index 14 therefore crosses the read-only entry and wraps to index 0 in one transfer. A read from index 15 after the count is set to 2 reaches the wrap, the count limit and the 8'hFF filler bytes within five bytes. Two strap settings are used, one of them with the 2'b11 code. SCL quarter periods are eight system clocks, leaving margin over the three-cycle synchroniser and edge-detect latency.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } smb_state_t;

    // Three-level strap code to level value: 00 -> 0, 01 -> 1, 1x -> 2
    function automatic logic [1:0] strap_level(input logic [1:0] code);
        unique case (code)
            2'b00:   strap_level = 2'd0;
            2'b01:   strap_level = 2'd1;
            default: strap_level = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
            sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
        end else begin
            scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
            sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
        end
    end

    assign scl_hi_o   = scl_s;
    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~scl_p;
    assign scl_fall_o = ~scl_s & scl_p;
    assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_strap_addr.sv
module smb_strap_addr #(
    parameter logic [6:0] BASE_ADDR = 7'h68
) (
    input  logic [1:0] sel0_i,
    input  logic [1:0] sel1_i,
    output logic [6:0] addr_o
);
    import smb_pkg::*;

    logic [7:0] sum;

    always_comb begin
        sum = {1'b0, BASE_ADDR}
            + 8'(3 * strap_level(sel1_i))
            + 8'(strap_level(sel0_i));
        addr_o = sum[6:0];
    end

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int         NREG    = 16,
    parameter int         IW      = $clog2(NREG),
    parameter int         CNT_IDX = 8,
    parameter logic [7:0] DEF_CNT = 8'd8,
    parameter int         RO_IDX  = 15,
    parameter logic [7:0] RO_VAL  = 8'h5A,
    parameter logic [7:0] RST_VAL = 8'hFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [IW-1:0]   waddr_i,
    input  logic [7:0]      wdata_i,
    input  logic [IW-1:0]   raddr_i,
    output logic [7:0]      rdata_o,
    output logic [7:0]      count_o,
    output logic [NREG*8-1:0] regs_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] r;
        if (g == RO_IDX) begin : g_ro
            assign r = RO_VAL;
        end else begin : g_rw
            localparam logic [7:0] INIT = (g == CNT_IDX) ? DEF_CNT : RST_VAL;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    r <= INIT;
                else if (we_i && waddr_i == IW'(g))
                    r <= wdata_i;
            end
        end
        assign regs_o[g*8 +: 8] = r;
    end

    assign rdata_o = regs_o[int'(raddr_i)*8 +: 8];
    assign count_o = regs_o[CNT_IDX*8 +: 8];

    // R3
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i != IW'(RO_IDX)) |=> regs_o[int'($past(waddr_i))*8 +: 8] == $past(wdata_i));

endmodule

// File: rtl/smb_blk_target.sv
module smb_blk_target #(
    parameter int         NREG      = 16,
    parameter logic [6:0] BASE_ADDR = 7'h68,
    parameter int         CNT_IDX   = 8,
    parameter logic [7:0] DEF_CNT   = 8'd8,
    parameter int         RO_IDX    = 15,
    parameter logic [7:0] RO_VAL    = 8'h5A,
    parameter logic [7:0] RST_VAL   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel0_i,
    input  logic [1:0]        addr_sel1_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] regs_o
);
    import smb_pkg::*;

    // NREG is a power of two so the index wraps naturally
    localparam int IW = $clog2(NREG);

    logic scl_hi, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [6:0] my_addr;

    smb_state_t state, state_n;
    logic [3:0]    bitcnt;
    logic [7:0]    sh;
    logic [7:0]    txsh;
    logic [IW-1:0] idx;
    logic [7:0]    rem;
    logic          rw;
    logic          host_ack;
    logic          byte_done;
    logic          reg_we;
    logic [7:0]    rdata, count;

    smb_line_mon u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_hi_o(scl_hi), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_p), .stop_o(stop_p)
    );

    smb_strap_addr #(.BASE_ADDR(BASE_ADDR)) u_addr (
        .sel0_i(addr_sel0_i), .sel1_i(addr_sel1_i), .addr_o(my_addr)
    );

    smb_regfile #(
        .NREG(NREG), .IW(IW), .CNT_IDX(CNT_IDX), .DEF_CNT(DEF_CNT),
        .RO_IDX(RO_IDX), .RO_VAL(RO_VAL), .RST_VAL(RST_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .waddr_i(idx),
        .wdata_i(sh), .raddr_i(idx), .rdata_o(rdata), .count_o(count),
        .regs_o(regs_o)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);

    // Next-state logic
    always_comb begin
        state_n = state;
        if (stop_p) begin
            state_n = ST_IDLE;
        end else if (start_p) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_n = ST_IDLE;
                ST_ADDR:      if (byte_done) state_n = (sh[7:1] == my_addr) ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (scl_fall) state_n = rw ? ST_TX : ST_INDEX;
                ST_INDEX:     if (byte_done) state_n = ST_INDEX_ACK;
                ST_INDEX_ACK: if (scl_fall) state_n = ST_COUNT;
                ST_COUNT:     if (byte_done) state_n = ST_COUNT_ACK;
                ST_COUNT_ACK: if (scl_fall) state_n = ST_WDATA;
                ST_WDATA:     if (byte_done) state_n = (rem != 8'd0) ? ST_WDATA_ACK : ST_WAIT;
                ST_WDATA_ACK: if (scl_fall) state_n = ST_WDATA;
                ST_TX:        if (scl_fall && bitcnt == 4'd7) state_n = ST_TX_ACK;
                ST_TX_ACK:    if (scl_fall) state_n = host_ack ? ST_TX : ST_WAIT;
                ST_WAIT:      state_n = ST_WAIT;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Datapath: shift registers, bit counter, index and remaining count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            sh       <= '0;
            txsh     <= 8'hFF;
            idx      <= '0;
            rem      <= '0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
        end else if (start_p || stop_p) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (scl_rise) begin
                        sh     <= {sh[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        bitcnt <= '0;
                        unique case (state)
                            ST_ADDR:  rw  <= sh[0];
                            ST_INDEX: idx <= sh[IW-1:0];
                            ST_COUNT: rem <= sh;
                            default: begin
                                if (rem != 8'd0) begin
                                    idx <= idx + IW'(1);
                                    rem <= rem - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw) begin
                        txsh   <= count;
                        rem    <= count;
                        bitcnt <= '0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            bitcnt <= '0;
                        end else begin
                            txsh   <= {txsh[6:0], 1'b1};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) host_ack <= ~sda_s;
                    if (scl_fall && host_ack) begin
                        if (rem != 8'd0) begin
                            txsh <= rdata;
                            idx  <= idx + IW'(1);
                            rem  <= rem - 8'd1;
                        end else begin
                            txsh <= 8'hFF;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_oe_o = 1'b0;
        reg_we   = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_TX:    sda_oe_o = ~txsh[7];
            ST_WDATA: reg_we   = byte_done && (rem != 8'd0);
            default: ;
        endcase
    end

    // R3
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> sda_oe_o);

    // R5
    count_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA_ACK && $past(state) == ST_WDATA)
        |-> ($past(rem) != 8'd0 && rem == $past(rem) - 8'd1));

    // R6
    count_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ADDR_ACK && state == ST_TX) |-> txsh == count);

    // R8
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi && $past(scl_hi) && !$past(start_p) && !$past(stop_p))
        |-> $stable(sda_oe_o));

endmodule

// File: tb/smb_blk_target_bench.sv
module smb_blk_target_bench;

    localparam int NREG = 16;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic [1:0] sel0 = 2'b01;
    logic [1:0] sel1 = 2'b10;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    logic sda_line;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] exp_r [NREG];

    always #2 clk = ~clk;

    assign sda_line = host_sda & ~sda_oe;

    smb_blk_target u_smb_blk_target (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
        .addr_sel0_i(sel0), .addr_sel1_i(sel1),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        host_sda = 1'b1; host_scl = 1'b1; tick(Q);
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input bit b);
        host_sda = b; tick(Q);
        host_scl = 1'b1; tick(2*Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        host_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            host_scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            host_scl = 1'b0;
        end
        host_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        host_scl = 1'b1; tick(2*Q);
        host_scl = 1'b0; tick(Q);
        host_sda = 1'b1;
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(regs[i*8 +: 8] == exp_r[i], tag, regs[i*8 +: 8], exp_r[i]);
    endtask

    task automatic block_write(input logic [7:0] wa, input logic [7:0] ix,
                               input logic [7:0] d0, input logic [7:0] d1,
                               input logic [7:0] d2, input int n, input string tag);
        bit a;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte(wa, a);            chk(a, {tag, " addr ack"}, a, 1);
        send_byte(ix, a);            chk(a, {tag, " index ack"}, a, 1);
        send_byte(8'(n), a);         chk(a, {tag, " count ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], a);      chk(a, {tag, " data ack"}, a, 1);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'hFF;
        exp_r[8]  = 8'd8;
        exp_r[15] = 8'h5A;
        check_regs("R9 reset image");
        chk(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);
    endtask

    task automatic t_nomatch();
        bit a;
        bus_start();
        send_byte(8'hDC, a); chk(!a, "R2 wrong address nack", a, 0);
        send_byte(8'h00, a); chk(!a, "R2 index ignored", a, 0);
        send_byte(8'h01, a); chk(!a, "R2 count ignored", a, 0);
        send_byte(8'h33, a); chk(!a, "R2 data ignored", a, 0);
        bus_stop();
        check_regs("R2 registers unchanged");
    endtask

    task automatic t_write_basic();
        block_write(8'hDE, 8'd2, 8'h11, 8'h22, 8'h33, 3, "R1 R3");
        exp_r[2] = 8'h11; exp_r[3] = 8'h22; exp_r[4] = 8'h33;
        check_regs("R3 block write");
    endtask

    task automatic t_write_wrap_ro();
        block_write(8'hDE, 8'd14, 8'hA1, 8'hB2, 8'hC3, 3, "R10 R4");
        exp_r[14] = 8'hA1; exp_r[0] = 8'hC3;
        check_regs("R4 wrap write");
        chk(regs[15*8 +: 8] == 8'h5A, "R10 read-only kept", regs[15*8 +: 8], 8'h5A);
    endtask

    task automatic t_overrun();
        bit a;
        bus_start();
        send_byte(8'hDE, a); send_byte(8'd4, a); send_byte(8'd1, a);
        send_byte(8'h44, a); chk(a, "R5 in-count ack", a, 1);
        send_byte(8'h55, a); chk(!a, "R5 beyond count nack", a, 0);
        bus_stop();
        exp_r[4] = 8'h44;
        bus_start();
        send_byte(8'hDE, a); send_byte(8'd6, a); send_byte(8'd0, a);
        send_byte(8'h66, a); chk(!a, "R5 zero count nack", a, 0);
        bus_stop();
        check_regs("R5 overrun not stored");
    endtask

    task automatic t_read_basic();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hDE, a); send_byte(8'd2, a);
        bus_rstart();
        send_byte(8'hDF, a); chk(a, "R6 read addr ack", a, 1);
        recv_byte(1'b1, b);  chk(b == 8'd8, "R6 count byte", b, 8);
        recv_byte(1'b1, b);  chk(b == 8'h11, "R6 byte N", b, 8'h11);
        recv_byte(1'b1, b);  chk(b == 8'h22, "R6 byte N+1", b, 8'h22);
        recv_byte(1'b0, b);  chk(b == 8'h44, "R6 byte N+2", b, 8'h44);
        tick(4*Q);
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_read_count();
        bit a;
        logic [7:0] b;
        block_write(8'hDE, 8'd8, 8'd2, 8'h00, 8'h00, 1, "R12 count write");
        exp_r[8] = 8'd2;
        check_regs("R12 count stored");
        bus_start();
        send_byte(8'hDE, a); send_byte(8'd15, a);
        bus_rstart();
        send_byte(8'hDF, a);
        recv_byte(1'b1, b); chk(b == 8'd2, "R12 count byte", b, 2);
        recv_byte(1'b1, b); chk(b == 8'h5A, "R12 byte 15", b, 8'h5A);
        recv_byte(1'b1, b); chk(b == 8'hC3, "R4 read wrap to 0", b, 8'hC3);
        recv_byte(1'b1, b); chk(b == 8'hFF, "R7 filler 1", b, 8'hFF);
        recv_byte(1'b0, b); chk(b == 8'hFF, "R7 filler 2", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_abort();
        bit a;
        bus_start();
        send_byte(8'hDE, a); send_byte(8'd3, a);
        bus_stop();
        bus_start();
        send_byte(8'hDE, a); send_byte(8'd9, a); send_byte(8'd2, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_rstart();
        send_byte(8'hDE, a); chk(a, "R11 address after mid-byte start", a, 1);
        send_byte(8'd9, a); send_byte(8'd1, a);
        send_byte(8'h77, a); chk(a, "R11 fresh data ack", a, 1);
        bus_stop();
        exp_r[9] = 8'h77;
        check_regs("R11 aborted transfers");
    endtask

    task automatic t_strap();
        bit a;
        sel0 = 2'b11; sel1 = 2'b00;
        tick(2);
        bus_start();
        send_byte(8'hDE, a); chk(!a, "R1 old address rejected", a, 0);
        bus_stop();
        block_write(8'hD4, 8'd1, 8'h5E, 8'h00, 8'h00, 1, "R1 new strap");
        exp_r[1] = 8'h5E;
        check_regs("R1 strap write");
    endtask

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_nomatch();
        t_write_basic();
        t_write_wrap_ro();
        t_overrun();
        t_read_basic();
        t_read_count();
        t_abort();
        t_strap();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule